// File: doc/BRIEF.md
# Half to single precision widener

This block takes a 16-bit half-precision floating-point bit pattern and returns the 32-bit single-precision bit pattern of the same value. Widening never loses information, so the block does no rounding and raises no flags. One mode input picks how the half exponent code 31 is read. In standard mode it encodes infinity or NaN. In alternative mode it is an ordinary finite binade, which gives the half format twice the range.

Subnormal half inputs are renormalised with a leading-zero count. The result for every nonzero input is therefore a normal single value. Inputs carry a valid strobe. The result lands in an output register one clock later, together with its own valid.

Top module: `half_to_single_widener`

## Requirements
- R1: For a half input with exponent code 1..30 (bits 14:10) and mantissa bits 9:0, the single result has exponent (bits 30:23) equal to the half exponent plus 112 (0x70). Its mantissa bits 22:13 equal the half mantissa and its bits 12:0 are zero. Both modes give this result.
- R2: For a half input with exponent code 0 and a nonzero mantissa, let z be the number of leading zeros in the 10-bit mantissa. The single exponent is 112 minus z. The single mantissa bits 22:13 hold the half mantissa shifted left by z+1 and cut to 10 bits, and bits 12:0 are zero. No result has exponent 0.
- R3: An input whose bits 14:0 are all zero gives a result whose bits 30:0 are all zero. The sign bit is kept.
- R4: When in_alt_mode is 0 and the exponent code is 31, the result exponent is 0xFF and the half mantissa is copied into bits 22:13. Infinity stays infinity and a NaN payload is kept.
- R5: When in_alt_mode is 1 and the exponent code is 31, the input is finite. The result exponent is 0x8F with the mantissa copied, and the exponent is never 0xFF.
- R6: Result bit 31 always equals input bit 15.
- R7: out_valid equals the in_valid of the previous clock. out_single shows the result for the input that was presented with in_valid high one clock earlier.
- R8: While in_valid is low, out_single keeps its value.
- R9: A synchronous active-high rst clears out_valid and out_single on the next clock edge. It wins over a valid input in the same cycle.
- R10: in_alt_mode changes no result other than those for exponent code 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input strobe; the register loads when it is high |
| in_half | input | 16 | Half-precision bit pattern (sign 15, exponent 14:10, mantissa 9:0) |
| in_alt_mode | input | 1 | 0: exponent code 31 is infinity/NaN; 1: it is finite |
| out_valid | output | 1 | Registered copy of in_valid |
| out_single | output | 32 | Single-precision bit pattern (sign 31, exponent 30:23, mantissa 22:0) |

## Verification
Two things can land on the same clock edge: a reset and a valid input that would load the register. The bench holds in_valid high with a nonzero code while rst is asserted, both at start-up and in the middle of a run. It then expects out_valid and out_single at zero one clock later, not the converted value. A second overlap is a mode flip between back-to-back inputs that use exponent code 31. Each output is judged against a behavioural model that rebuilds the value with real arithmetic, so the mode sampled on each cycle must match that cycle's input.

// File: rtl/hw_fmt_pkg.sv
package hw_fmt_pkg;

    localparam int H_EXP_W   = 5;
    localparam int H_MAN_W   = 10;
    localparam int S_EXP_W   = 8;
    localparam int S_MAN_W   = 23;

    localparam int H_W       = 1 + H_EXP_W + H_MAN_W;
    localparam int S_W       = 1 + S_EXP_W + S_MAN_W;
    localparam int H_BIAS    = (1 << (H_EXP_W - 1)) - 1;
    localparam int S_BIAS    = (1 << (S_EXP_W - 1)) - 1;
    localparam int BIAS_GAP  = S_BIAS - H_BIAS;
    localparam int MAN_PAD   = S_MAN_W - H_MAN_W;
    localparam int LZ_W      = $clog2(H_MAN_W + 1);

    typedef struct packed {
        logic               sign;
        logic [H_EXP_W-1:0] exp;
        logic [H_MAN_W-1:0] man;
    } half_t;

    typedef struct packed {
        logic               sign;
        logic [S_EXP_W-1:0] exp;
        logic [S_MAN_W-1:0] man;
    } single_t;

    // How an incoming half code is to be widened
    typedef enum logic [2:0] {
        CLS_ZERO,     // magnitude zero
        CLS_SUB,      // subnormal, needs renormalising
        CLS_NORM,     // ordinary normal code
        CLS_SPECIAL,  // top code in standard mode: infinity or NaN
        CLS_TOPFIN    // top code in alternative mode: finite
    } cls_e;

endpackage

// File: rtl/hw_lead_zero.sv
module hw_lead_zero #(
    parameter int WIDTH = 10,
    localparam int CW = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [CW-1:0]    count
);

    always_comb begin
        logic found;
        found = 1'b0;
        count = CW'(WIDTH);
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (!found && vec[i]) begin
                count = CW'(WIDTH - 1 - i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/hw_half_classify.sv
module hw_half_classify
    import hw_fmt_pkg::*;
(
    input  half_t hin,
    input  logic  alt_mode,
    output cls_e  cls
);

    logic exp_zero;
    logic exp_top;
    logic man_zero;

    assign exp_zero = (hin.exp == '0);
    assign exp_top  = (hin.exp == '1);
    assign man_zero = (hin.man == '0);

    always_comb begin
        if (exp_zero && man_zero)      cls = CLS_ZERO;
        else if (exp_zero)             cls = CLS_SUB;
        else if (exp_top && !alt_mode) cls = CLS_SPECIAL;
        else if (exp_top)              cls = CLS_TOPFIN;
        else                           cls = CLS_NORM;
    end

endmodule

// File: rtl/hw_single_assemble.sv
module hw_single_assemble
    import hw_fmt_pkg::*;
(
    input  half_t            hin,
    input  cls_e             cls,
    input  logic [LZ_W-1:0]  lz,
    output single_t          sout
);

    logic [H_MAN_W-1:0] sub_frac;
    logic [S_EXP_W-1:0] norm_exp;
    logic [S_EXP_W-1:0] sub_exp;

    // Drop the leading one into the hidden position
    assign sub_frac = hin.man << (lz + LZ_W'(1));
    assign norm_exp = S_EXP_W'(hin.exp) + S_EXP_W'(BIAS_GAP);
    assign sub_exp  = S_EXP_W'(BIAS_GAP) - S_EXP_W'(lz);

    always_comb begin
        sout.sign = hin.sign;
        unique case (cls)
            CLS_ZERO: begin
                sout.exp = '0;
                sout.man = '0;
            end
            CLS_SUB: begin
                sout.exp = sub_exp;
                sout.man = {sub_frac, {MAN_PAD{1'b0}}};
            end
            CLS_SPECIAL: begin
                sout.exp = '1;
                sout.man = {hin.man, {MAN_PAD{1'b0}}};
            end
            CLS_NORM, CLS_TOPFIN: begin
                sout.exp = norm_exp;
                sout.man = {hin.man, {MAN_PAD{1'b0}}};
            end
            default: begin
                sout.exp = '0;
                sout.man = '0;
            end
        endcase
    end

endmodule

// File: rtl/half_to_single_widener.sv
module half_to_single_widener
    import hw_fmt_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [H_W-1:0] in_half,
    input  logic           in_alt_mode,
    output logic           out_valid,
    output logic [S_W-1:0] out_single
);

    half_t             hin;
    cls_e              cls;
    logic [LZ_W-1:0]   lz;
    single_t           wide;

    assign hin = half_t'(in_half);

    hw_half_classify u_classify (
        .hin      (hin),
        .alt_mode (in_alt_mode),
        .cls      (cls)
    );

    hw_lead_zero #(.WIDTH(H_MAN_W)) u_lead_zero (
        .vec   (hin.man),
        .count (lz)
    );

    hw_single_assemble u_assemble (
        .hin  (hin),
        .cls  (cls),
        .lz   (lz),
        .sout (wide)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_single <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_single <= S_W'(wide);
            end
        end
    end

endmodule

// File: rtl/hw_widen_chk.sv
module hw_widen_chk
    import hw_fmt_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [H_W-1:0] in_half,
    input logic           in_alt_mode,
    input logic           out_valid,
    input logic [S_W-1:0] out_single
);

    assert_valid_delay_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    assert_sign_kept_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_single[S_W-1] == $past(in_half[H_W-1])));

    assert_zero_mag_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(in_half[H_W-2:0]) == '0)) |-> (out_single[S_W-2:0] == '0));

    assert_no_subnormal_out_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(in_half[H_W-2:0]) != '0))
            |-> (out_single[S_W-2:S_MAN_W] != '0));

    assert_special_top_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(in_alt_mode) && ($past(in_half[H_W-2:H_MAN_W]) == '1))
            |-> (out_single[S_W-2:S_MAN_W] == '1));

    assert_alt_finite_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_alt_mode)) |-> (out_single[S_W-2:S_MAN_W] != '1));

    assert_low_pad_zero_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_single[MAN_PAD-1:0] == '0));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> $stable(out_single));

    assert_reset_clear_R9: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && (out_single == '0)));

endmodule

bind half_to_single_widener hw_widen_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_half     (in_half),
    .in_alt_mode (in_alt_mode),
    .out_valid   (out_valid),
    .out_single  (out_single)
);

// File: tb/test_half_to_single_widener.sv
module test_half_to_single_widener;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_half = '0;
    logic        in_alt_mode = 1'b0;
    logic        out_valid;
    logic [31:0] out_single;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    logic [31:0] held = '0;

    always #5 clk = ~clk;

    half_to_single_widener i_half_to_single_widener (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_half     (in_half),
        .in_alt_mode (in_alt_mode),
        .out_valid   (out_valid),
        .out_single  (out_single)
    );

    // Behavioural model: rebuild the numeric value, then re-encode it
    function automatic logic [31:0] model(input logic [15:0] h, input bit alt);
        logic       s = h[15];
        int         e = int'(h[14:10]);
        int         m = int'(h[9:0]);
        real        v;
        int         ex = 0;
        int         frac;
        if (e == 31 && !alt) return {s, 8'hFF, h[9:0], 13'b0};
        if (e == 0 && m == 0) return {s, 31'b0};
        if (e == 0) begin
            v = real'(m);
            for (int k = 0; k < 24; k++) v = v / 2.0;
        end else begin
            v = real'(1024 + m);
            if (e >= 25) for (int k = 0; k < e - 25; k++) v = v * 2.0;
            else         for (int k = 0; k < 25 - e; k++) v = v / 2.0;
        end
        while (v >= 2.0) begin v = v / 2.0; ex++; end
        while (v < 1.0)  begin v = v * 2.0; ex--; end
        frac = $rtoi((v - 1.0) * 8388608.0);
        return {s, 8'(ex + 127), 23'(frac)};
    endfunction

    function automatic string tag_of(input logic [15:0] h, input bit alt);
        if (h[14:10] == 5'd31) return alt ? "R5" : "R4";
        if (h[14:0] == 15'd0)  return "R3";
        if (h[14:10] == 5'd0)  return "R2";
        return "R1";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge
    task automatic step(input bit v, input bit alt, input logic [15:0] code,
                        input string tag);
        logic [31:0] exp_val;
        in_valid    = v;
        in_alt_mode = alt;
        in_half     = code;
        @(negedge clk);
        if (v) begin
            exp_val = model(code, alt);
            held    = exp_val;
            check("R7", "out_valid high", {31'b0, out_valid}, 32'd1);
            check(tag, $sformatf("code=%h mode=%0d", code, alt), out_single, exp_val);
        end else begin
            check("R7", "out_valid low", {31'b0, out_valid}, 32'd0);
            check("R8", "hold while idle", out_single, held);
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog: got=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: reset wins over a valid input in the same cycle
        rst = 1'b1; in_valid = 1'b1; in_half = 16'h3C00;
        @(negedge clk); @(negedge clk);
        check("R9", "out_valid under reset", {31'b0, out_valid}, 32'd0);
        check("R9", "out_single under reset", out_single, 32'd0);
        rst = 1'b0;

        step(1'b1, 1'b0, 16'h3C00, "R1");   // 1.0 -> 0x3F800000
        check("R1", "one", out_single, 32'h3F80_0000);
        step(1'b1, 1'b1, 16'h3C00, "R10");  // mode has no effect here
        check("R10", "one alt", out_single, 32'h3F80_0000);
        step(1'b1, 1'b0, 16'h0001, "R2");
        check("R2", "smallest subnormal", out_single, 32'h3380_0000);
        step(1'b1, 1'b0, 16'h03FF, "R2");
        check("R2", "largest subnormal", out_single, 32'h387F_C000);
        step(1'b1, 1'b0, 16'h8000, "R3");
        check("R3", "negative zero", out_single, 32'h8000_0000);
        step(1'b1, 1'b0, 16'hC000, "R6");
        check("R6", "minus two", out_single, 32'hC000_0000);
        step(1'b1, 1'b0, 16'h7C00, "R4");
        check("R4", "infinity", out_single, 32'h7F80_0000);
        step(1'b1, 1'b0, 16'h7E01, "R4");
        check("R4", "nan payload", out_single, 32'h7FC0_2000);
        step(1'b1, 1'b1, 16'h7C00, "R5");   // mode flip on top code
        check("R5", "alt top code", out_single, 32'h4780_0000);
        step(1'b1, 1'b1, 16'hFFFF, "R5");
        check("R5", "alt largest negative", out_single, 32'hC7FF_E000);
        step(1'b0, 1'b0, 16'h1234, "R8");
        step(1'b0, 1'b1, 16'h7C00, "R8");

        // R9 in mid-run, again against a valid input
        rst = 1'b1; in_valid = 1'b1; in_half = 16'h4500;
        @(negedge clk);
        check("R9", "mid-run reset valid", {31'b0, out_valid}, 32'd0);
        check("R9", "mid-run reset data", out_single, 32'd0);
        held = '0;
        rst = 1'b0;
        step(1'b0, 1'b0, 16'h4500, "R8");

        // Full sweep, both modes, with an occasional idle cycle
        for (int md = 0; md < 2; md++) begin
            for (int c = 0; c < 65536; c++) begin
                step(1'b1, md[0], 16'(c), tag_of(16'(c), md[0]));
                if ((c % 8192) == 8191) step(1'b0, md[0], 16'(c), "R8");
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule